// File: doc/BRIEF.md
# Nibble-Serial Clock Register Access Controller

This block sits between a host bus and a sixteen-entry, nibble-wide clock register bank. The host sees three byte-wide registers: a chip-enable register, a data port and a status register. Every command, register index and data nibble goes through the single data port in a fixed order. A mode command picks the direction, a seek nibble places the register cursor, and then nibbles are transferred one per access. The cursor steps forward after each transfer and wraps from 15 to 0.

The block drives a cursor-addressed write strobe and read strobe into the attached register bank. It also pulses a control-clear line that tells the bank to drop its resync, pause and test control bits. Accesses take effect at once, so the ready flag never drops once it has been raised. A host that polls for ready therefore succeeds on its next check. The register contents and any timekeeping belong to the attached bank and are not part of this block.

Top module: `rtc_nibble_host`

## Requirements
- R1: The host address is decoded on its two low bits only: 0 selects chip enable, 1 selects the data port and 2 selects status. Address 3 reads as 0x00 and writes to it change nothing.
- R2: Only bits 3:0 of any host write are used. Bits 7:4 have no effect.
- R3: A write to the chip-enable address stores the nibble. A read of that address returns the stored nibble in bits 3:0, with bits 7:4 zero.
- R4: A chip-enable write of any value other than 1 returns the protocol to the mode state with the cursor at 0, and pulses `ctl_clear` for that one cycle.
- R5: Data-port accesses are only honoured when chip enable holds 1 and ready is set. Otherwise a data write causes no strobe and no state change, and a data read returns 0x00.
- R6: In the mode state, only the data values 0x3 (write command) and 0xC (read command) are accepted. Either one is latched and moves the protocol to the seek state. Any other value leaves the protocol in the mode state.
- R7: In the seek state, a data write loads its nibble into the cursor and into the latch. The protocol then enters the write state if the latched command was 0x3, and the read state otherwise.
- R8: In the write state, each data write issues `reg_wr` with `reg_addr` equal to the cursor and `reg_wdata` equal to the nibble. It latches the nibble and advances the cursor modulo 16. In the read state, data writes are ignored.
- R9: In the read state, each data read returns the bank nibble at the cursor in bits 3:0 and pulses `reg_rd`. The cursor advances modulo 16 at that clock edge.
- R10: In the write state, a data read returns the latched nibble and leaves the cursor unchanged. In the mode and seek states, a data read returns 0x00.
- R11: A status read returns the ready flag in bit 7, with bits 6:0 zero.
- R12: After reset, ready is clear, chip enable holds 0, and the protocol is in the mode state with cursor and latch at 0. Every chip-enable write, and every accepted data write, sets ready, and ready is never cleared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wr | input | 1 | Single-cycle host write strobe (wins over host_rd) |
| host_addr | input | ADDR_W | Host address; only bits 1:0 are decoded |
| host_wdata | input | HOST_DW | Host write data |
| host_rdata | output | HOST_DW | Host read data, combinational from current state |
| reg_addr | output | 4 | Cursor index into the register bank |
| reg_wdata | output | 4 | Nibble written to the bank |
| reg_wr | output | 1 | Bank write strobe |
| reg_rd | output | 1 | Bank read strobe (cursor advance) |
| reg_rdata | input | 4 | Bank nibble at reg_addr |
| ctl_clear | output | 1 | Pulse asking the bank to clear its resync, pause and test bits |

## Verification
The hardest situation to reach from the ports is the protocol's rejection paths. A rejected mode command looks exactly like an accepted one until later accesses reveal which state the block is in. The stimulus therefore tries every one of the 16 nibbles as a mode command. Each try is followed by a fixed probe pair: a seek-like nibble and then a data nibble. A reference model predicts the result of the final data read and the number of bank write strobes. The cursor wrap and the gating by chip enable are reached in the same way. The bench pushes the cursor across index 15 in both directions, and it repeats the whole command sequence under every non-one chip-enable value.

// File: rtl/rtc_hs_pkg.sv
package rtc_hs_pkg;
  localparam int NIB_W   = 4;
  localparam int CUR_W   = 4;
  localparam logic [NIB_W-1:0] CMD_STORE = 4'h3;
  localparam logic [NIB_W-1:0] CMD_FETCH = 4'hC;
  localparam logic [NIB_W-1:0] CS_LIVE   = 4'h1;

  typedef enum logic [1:0] {
    ST_MODE  = 2'd0,
    ST_SEEK  = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } hs_state_e;

  function automatic logic is_command(input logic [NIB_W-1:0] nib);
    return (nib == CMD_STORE) || (nib == CMD_FETCH);
  endfunction

  function automatic logic [CUR_W-1:0] step_cursor(input logic [CUR_W-1:0] cur);
    return cur + CUR_W'(1);
  endfunction

  function automatic hs_state_e seek_target(input logic [NIB_W-1:0] cmd);
    return (cmd == CMD_STORE) ? ST_WRITE : ST_READ;
  endfunction
endpackage

// File: rtl/rtc_hs_decode.sv
module rtc_hs_decode #(
  parameter int ADDR_W  = 4,
  parameter int HOST_DW = 8
) (
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic               cs_wr,
  output logic               dat_wr,
  output logic               cs_rd,
  output logic               dat_rd,
  output logic               st_rd,
  output logic [3:0]         nib
);
  logic [1:0] port_sel;
  logic       rd_eff;
  logic       unused_hi;

  assign port_sel  = host_addr[1:0];
  assign rd_eff    = host_rd && !host_wr;
  assign nib       = host_wdata[3:0];
  assign unused_hi = ^{host_addr[ADDR_W-1:2], host_wdata[HOST_DW-1:4]};

  assign cs_wr  = host_wr && (port_sel == 2'd0);
  assign dat_wr = host_wr && (port_sel == 2'd1);
  assign cs_rd  = rd_eff  && (port_sel == 2'd0);
  assign dat_rd = rd_eff  && (port_sel == 2'd1);
  assign st_rd  = rd_eff  && (port_sel == 2'd2);

  always_comb begin
    assert ($countones({cs_wr, dat_wr, cs_rd, dat_rd, st_rd}) <= 1)
      else $error("p_one_port_r1 violated");
  end
endmodule

// File: rtl/rtc_hs_seq.sv
module rtc_hs_seq
  import rtc_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_wr,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic [NIB_W-1:0] nib,
  output logic [NIB_W-1:0] cs_q,
  output logic             ready_q,
  output hs_state_e        state_q,
  output logic [CUR_W-1:0] cursor_q,
  output logic [NIB_W-1:0] latch_q,
  output logic             gate_open,
  output logic             xfer_wr,
  output logic             xfer_rd,
  output logic             cs_drop
);
  logic acc_wr;
  logic acc_rd;
  logic mode_take;
  logic seek_take;

  assign gate_open = (cs_q == CS_LIVE) && ready_q;
  assign acc_wr    = dat_wr && gate_open;
  assign acc_rd    = dat_rd && gate_open;
  assign mode_take = acc_wr && (state_q == ST_MODE) && is_command(nib);
  assign seek_take = acc_wr && (state_q == ST_SEEK);
  assign xfer_wr   = acc_wr && (state_q == ST_WRITE);
  assign xfer_rd   = acc_rd && (state_q == ST_READ);
  assign cs_drop   = cs_wr && (nib != CS_LIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= '0;
      ready_q  <= 1'b0;
      state_q  <= ST_MODE;
      cursor_q <= '0;
      latch_q  <= '0;
    end else if (cs_wr) begin
      cs_q    <= nib;
      ready_q <= 1'b1;
      if (cs_drop) begin
        state_q  <= ST_MODE;
        cursor_q <= '0;
      end
    end else begin
      if (acc_wr) ready_q <= 1'b1;
      if (mode_take) begin
        state_q <= ST_SEEK;
        latch_q <= nib;
      end else if (seek_take) begin
        state_q  <= seek_target(latch_q);
        cursor_q <= nib;
        latch_q  <= nib;
      end else if (xfer_wr) begin
        latch_q  <= nib;
        cursor_q <= step_cursor(cursor_q);
      end else if (xfer_rd) begin
        cursor_q <= step_cursor(cursor_q);
      end
    end
  end

  p_drop_to_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_drop |=> (state_q == ST_MODE) && (cursor_q == '0));

  p_ready_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);

  p_mode_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !cs_wr && state_q == ST_MODE && nib != CMD_STORE && nib != CMD_FETCH)
      |=> (state_q == ST_MODE));

  p_seek_cursor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seek_take |=> (cursor_q == $past(nib)) && (state_q == ST_WRITE || state_q == ST_READ));

  p_write_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_wr |=> (cursor_q == $past(cursor_q) + 4'd1) && (latch_q == $past(nib)));

  p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_rd |=> (cursor_q == $past(cursor_q) + 4'd1) && $stable(latch_q));

  p_closed_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !gate_open) |=> $stable(state_q) && $stable(cursor_q) && $stable(latch_q));
endmodule

// File: rtl/rtc_hs_rdmux.sv
module rtc_hs_rdmux
  import rtc_hs_pkg::*;
#(
  parameter int HOST_DW = 8
) (
  input  logic               cs_rd,
  input  logic               dat_rd,
  input  logic               st_rd,
  input  logic               gate_open,
  input  hs_state_e          state_q,
  input  logic [NIB_W-1:0]   cs_q,
  input  logic [NIB_W-1:0]   latch_q,
  input  logic               ready_q,
  input  logic [NIB_W-1:0]   reg_rdata,
  output logic [HOST_DW-1:0] host_rdata
);
  localparam int PAD_W = HOST_DW - NIB_W;

  logic [NIB_W-1:0] dat_nib;

  always_comb begin
    dat_nib = '0;
    if (gate_open) begin
      case (state_q)
        ST_WRITE: dat_nib = latch_q;
        ST_READ:  dat_nib = reg_rdata;
        default:  dat_nib = '0;
      endcase
    end
  end

  always_comb begin
    host_rdata = '0;
    if (cs_rd)       host_rdata = {{PAD_W{1'b0}}, cs_q};
    else if (dat_rd) host_rdata = {{PAD_W{1'b0}}, dat_nib};
    else if (st_rd)  host_rdata = {ready_q, {(HOST_DW-1){1'b0}}};
  end

  always_comb begin
    if (st_rd) assert (host_rdata[HOST_DW-2:0] == '0)
      else $error("p_status_format_r11 violated");
    if (dat_rd && (state_q == ST_MODE || state_q == ST_SEEK))
      assert (host_rdata == '0) else $error("p_idle_read_zero_r10 violated");
  end
endmodule

// File: rtl/rtc_nibble_host.sv
module rtc_nibble_host
  import rtc_hs_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int HOST_DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic [3:0]         reg_addr,
  output logic [3:0]         reg_wdata,
  output logic               reg_wr,
  output logic               reg_rd,
  input  logic [3:0]         reg_rdata,
  output logic               ctl_clear
);
  logic             cs_wr, dat_wr, cs_rd, dat_rd, st_rd;
  logic [NIB_W-1:0] nib;
  logic [NIB_W-1:0] cs_q, latch_q;
  logic             ready_q, gate_open, xfer_wr, xfer_rd, cs_drop;
  logic [CUR_W-1:0] cursor_q;
  hs_state_e        state_q;

  rtc_hs_decode #(.ADDR_W(ADDR_W), .HOST_DW(HOST_DW)) u_decode (
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .cs_wr(cs_wr), .dat_wr(dat_wr),
    .cs_rd(cs_rd), .dat_rd(dat_rd), .st_rd(st_rd), .nib(nib)
  );

  rtc_hs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cs_wr(cs_wr), .dat_wr(dat_wr),
    .dat_rd(dat_rd), .nib(nib), .cs_q(cs_q), .ready_q(ready_q),
    .state_q(state_q), .cursor_q(cursor_q), .latch_q(latch_q),
    .gate_open(gate_open), .xfer_wr(xfer_wr), .xfer_rd(xfer_rd),
    .cs_drop(cs_drop)
  );

  rtc_hs_rdmux #(.HOST_DW(HOST_DW)) u_rdmux (
    .cs_rd(cs_rd), .dat_rd(dat_rd), .st_rd(st_rd), .gate_open(gate_open),
    .state_q(state_q), .cs_q(cs_q), .latch_q(latch_q), .ready_q(ready_q),
    .reg_rdata(reg_rdata), .host_rdata(host_rdata)
  );

  assign reg_addr  = cursor_q;
  assign reg_wdata = nib;
  assign reg_wr    = xfer_wr;
  assign reg_rd    = xfer_rd;
  assign ctl_clear = cs_drop;

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_wr_in_write_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (state_q == ST_WRITE) && (cs_q == CS_LIVE));

  p_rd_in_read_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (state_q == ST_READ) && (cs_q == CS_LIVE));
endmodule

// File: tb/rtc_nibble_host_tb.sv
module rtc_nibble_host_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [3:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd, ctl_clear;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [3:0] bank [16];
  logic [3:0] m_mem [16];
  int m_cs, m_rdy, m_st, m_cur, m_lat;
  int exp_clr = 0, seen_clr = 0, exp_wr = 0, seen_wr = 0;

  rtc_nibble_host u_dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .ctl_clear(ctl_clear)
  );

  always #2 clk = ~clk;

  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) begin
    if (reg_wr) begin bank[reg_addr] <= reg_wdata; seen_wr++; end
    if (ctl_clear) seen_clr++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cs = 0; m_rdy = 0; m_st = 0; m_cur = 0; m_lat = 0;
  endtask

  task automatic hw(input logic [3:0] a, input logic [7:0] d);
    int nv;
    nv = int'(d[3:0]);
    case (a[1:0])
      2'd0: begin
        m_cs = nv; m_rdy = 1;
        if (nv != 1) begin m_st = 0; m_cur = 0; exp_clr++; end
      end
      2'd1: if (m_cs == 1 && m_rdy == 1) begin
        case (m_st)
          0: if (nv == 3 || nv == 12) begin m_st = 1; m_lat = nv; end
          1: begin m_st = (m_lat == 3) ? 2 : 3; m_cur = nv; m_lat = nv; end
          2: begin m_mem[m_cur] = 4'(nv); m_lat = nv; m_cur = (m_cur + 1) % 16; exp_wr++; end
          default: ;
        endcase
      end
      default: ;
    endcase
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, input string tag);
    int ex;
    ex = 0;
    case (a[1:0])
      2'd0: ex = m_cs;
      2'd1: if (m_cs == 1 && m_rdy == 1) begin
        if (m_st == 2) ex = m_lat;
        else if (m_st == 3) begin ex = int'(m_mem[m_cur]); m_cur = (m_cur + 1) % 16; end
      end
      2'd2: ex = m_rdy * 128;
      default: ex = 0;
    endcase
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 check(tag, int'(host_rdata), ex);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin bank[i] = '0; m_mem[i] = '0; end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state: ready clear, chip enable 0, data reads zero
    hr(4'd2, "R12 status after reset");
    hr(4'd0, "R12 chip enable after reset");
    hr(4'd1, "R5 data read after reset");
    hr(4'd3, "R1 address 3 reads zero");

    // R3 R11 R12: every chip-enable value, read back; R1 address 3 write ignored
    for (int v = 0; v < 16; v++) begin
      hw(4'd0, 8'(v));
      hr(4'd0, "R3 chip enable readback");
      hr(4'd2, "R11 status ready bit");
      hw(4'd3, 8'hFF);
      hr(4'd0, "R1 address 3 write ignored");
    end

    // R6 R7 R8 R10: every nibble as a mode command, then probe
    for (int v = 0; v < 16; v++) begin
      hw(4'd0, 8'h00);
      hw(4'd0, 8'h01);
      hw(4'd1, 8'(v));
      hr(4'd1, "R10 mode/seek read zero");
      hw(4'd1, 8'h05);
      hr(4'd1, "R7 state after seek");
      hw(4'd1, 8'h09);
      hr(4'd1, "R6 R8 R9 probe read");
      hw(4'd1, 8'h0A);
      hr(4'd1, "R9 R10 second probe read");
    end

    // R8 R2: write wrap from 15 to 0, upper bits ignored, address alias via bit 2
    hw(4'd0, 8'h00); hw(4'd0, 8'h01);
    hw(4'd1, 8'h03); hw(4'd1, 8'h0E);
    for (int i = 0; i < 5; i++) begin
      hw(4'd5, 8'hA0 | 8'(i + 2));
      hr(4'd1, "R10 read returns latch in write state");
    end
    hr(4'd1, "R10 latch read leaves cursor");

    // R5: with chip enable != 1, nothing is accepted, reads zero
    for (int c = 0; c < 16; c++) begin
      if (c == 1) continue;
      hw(4'd0, 8'(c));
      hw(4'd1, 8'h03); hw(4'd1, 8'h00); hw(4'd1, 8'h0F);
      hr(4'd1, "R5 gated data read");
    end

    // R9: read wrap from 15 to 0 and readback of all bank nibbles
    hw(4'd0, 8'h00); hw(4'd0, 8'h01);
    hw(4'd1, 8'hFC); hw(4'd1, 8'h0F);
    for (int i = 0; i < 18; i++) hr(4'd1, "R9 sequential read");
    hw(4'd1, 8'h07);
    hr(4'd1, "R8 write in read state ignored");

    // R4 R12: drop on a non-one chip enable returns to mode, ready stays
    hw(4'd0, 8'h07);
    hw(4'd0, 8'h01);
    hw(4'd1, 8'h05);
    hr(4'd1, "R4 back in mode after drop");
    hr(4'd2, "R12 ready kept");

    @(negedge clk);
    for (int i = 0; i < 16; i++) check("R8 bank content", int'(bank[i]), int'(m_mem[i]));
    check("R8 write strobe count", seen_wr, exp_wr);
    check("R4 ctl_clear pulse count", seen_clr, exp_clr);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule